// File: doc/BRIEF.md
# Single-Pin Configuration Command Sequencer

This block sits behind a bit decoder that turns a single-wire configuration pin into a stream of bits, each qualified by a one-cycle strobe. It interprets that stream as a small command language. While idle it watches for one of two six-bit entry codes. One code opens a programming session. The other opens a readback session.

Inside a programming session, each eleven-bit command carries a three-bit target followed by eight data bits. A target that names one of six shadow configuration words loads that word at once, so its effect is visible before anything is made permanent. The target pattern 111 instead marks a jump command. Two jump codes move the sequencer into a commit state, one that seals the non-volatile store and one that leaves it rewritable. A third jump code leaves a commit state, but only after a minimum dwell measured in millisecond ticks. Entry into a commit state produces a single pulse, tagged with the sealing choice, that a storage controller can act on. Once a sealing commit has been issued, later commits produce no pulse.

The chip-enable input reaches the power-down output only while the sequencer is idle. The decoder's timeout flag throws away any partly assembled frame.

Top module: `cfg_cmd_fsm`

## Requirements
- R1: After reset the state output is 0 (idle), all six shadow words are 0x00, and commit_pulse, commit_lock and readback_req are low.
- R2: From idle, the six bits 0,0,1,1,0,0 in arrival order move the state to 1 (programming) on the clock edge that takes the last bit.
- R3: From idle, the six bits 1,1,1,0,1,1 move the state to 4 (readback) and raise readback_req for exactly one cycle. After RB_STROBES further strobes the state returns to 0.
- R4: A six-bit frame in idle that matches neither entry code is discarded, and the state stays 0.
- R5: A high timeout input discards the bits collected so far, and the next frame starts from its first bit.
- R6: In programming, an 11-bit command whose first three arrival bits are 000, 100, 010, 110, 001 or 101 writes the following eight bits (first bit is the MSB) to word 0, 1, 2, 3, 4 or 5. The write lands on the edge of the last bit. Word i occupies cfg_words[8i+7:8i].
- R7: In programming, jump 111 followed by 0x55 enters state 2 (commit, sealing) and jump 111 followed by 0xF0 enters state 3 (commit, open). The entry raises commit_pulse for one cycle, and commit_lock reads 1 for the sealing code and 0 for the open code.
- R8: In programming, a 111-prefixed command with any other payload returns the state to 0.
- R9: In a commit state, the exit command 111 followed by 0x00 returns to 0 only after DWELL_MS ms_tick pulses have been counted since entry. An earlier exit command is ignored, and the state is kept.
- R10: After a sealing commit has pulsed, later jumps into either commit state change the state but give no commit_pulse.
- R11: pwr_dn equals the inverse of chip_en in state 0 and is 0 in every other state.
- R12: In a commit state, word writes and all commands other than the timely exit leave the shadow words and the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_val | input | 1 | Decoded bit value |
| bit_stb | input | 1 | One-cycle qualifier for bit_val |
| tmo | input | 1 | Decoder timeout; clears the partial frame |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| chip_en | input | 1 | External chip enable |
| cfg_words | output | 48 | Six shadow words, word i at bits 8i+7:8i |
| state_o | output | 3 | 0 idle, 1 programming, 2 commit sealing, 3 commit open, 4 readback |
| commit_pulse | output | 1 | One-cycle pulse on commit entry |
| commit_lock | output | 1 | Sealing flag of the latest commit |
| readback_req | output | 1 | One-cycle pulse on readback entry |
| pwr_dn | output | 1 | Power-down request |

## Verification
The assertions assume that bit_stb is a single-cycle pulse and that ms_tick pulses arrive only at the cadence of the real millisecond time base. They also rely on the decoder never asserting tmo and bit_stb in the same cycle. The stimulus drives each bit as an isolated one-cycle strobe with an idle cycle after it, and it raises tmo only between bits. It keeps ms_tick off during the early-exit test so that the dwell cannot expire by accident, then switches on a tick every four clocks to let the dwell elapse.

// File: rtl/cfg_cmd_pkg.sv
package cfg_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PROG     = 3'd1,
    ST_CMT_LOCK = 3'd2,
    ST_CMT_OPEN = 3'd3,
    ST_RDBK     = 3'd4
  } cfg_state_e;

  localparam int NUM_WORDS = 6;
  localparam int WORD_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int ENTRY_LEN = 6;
  localparam int CMD_LEN   = ADDR_W + WORD_W;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  localparam logic [ENTRY_LEN-1:0] SEQ_PROG = 6'b001100;
  localparam logic [ENTRY_LEN-1:0] SEQ_RDBK = 6'b111011;
  localparam logic [ADDR_W-1:0]    JMP_TAG  = 3'b111;
  localparam logic [WORD_W-1:0]    JMP_LOCK = 8'h55;
  localparam logic [WORD_W-1:0]    JMP_OPEN = 8'hF0;
  localparam logic [WORD_W-1:0]    JMP_EXIT = 8'h00;
endpackage

// File: rtl/cfg_bit_framer.sv
module cfg_bit_framer #(
  parameter int MAX_LEN = 11,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               bit_stb,
  input  logic               bit_val,
  input  logic [LW-1:0]      frame_len,
  output logic               frame_done,
  output logic [MAX_LEN-1:0] frame_word
);
  logic [LW-1:0]      cnt_q, cnt_d;
  logic [MAX_LEN-2:0] shf_q, shf_d;

  assign frame_word = {shf_q, bit_val};
  assign frame_done = bit_stb && !clr && (cnt_q == frame_len - LW'(1));

  always_comb begin
    cnt_d = cnt_q;
    shf_d = shf_q;
    if (clr || frame_done) begin
      cnt_d = '0;
      shf_d = '0;
    end else if (bit_stb) begin
      cnt_d = cnt_q + LW'(1);
      shf_d = {shf_q[MAX_LEN-3:0], bit_val};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      shf_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      shf_q <= shf_d;
    end
  end

  // R5
  clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || frame_done) |=> (cnt_q == '0));
endmodule

// File: rtl/cfg_evt_count.sv
module cfg_evt_count #(
  parameter int LIMIT = 10,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic inc,
  output logic reached
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign reached = (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                    cnt_d = '0;
    else if (inc && !reached)   cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !reached);
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
  parameter int N = 6,
  parameter int W = 8,
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [W-1:0]   wr_data,
  output logic [N*W-1:0] words_o
);
  for (genvar i = 0; i < N; i++) begin : g_word
    logic [W-1:0] word_q;
    logic         hit;
    assign hit = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= wr_data;
    end
    assign words_o[i*W +: W] = word_q;
  end

  // R12
  hold_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(words_o));
endmodule

// File: rtl/cfg_cmd_fsm.sv
module cfg_cmd_fsm
  import cfg_cmd_pkg::*;
#(
  parameter int DWELL_MS   = 10,
  parameter int RB_STROBES = 60
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_val,
  input  logic                        bit_stb,
  input  logic                        tmo,
  input  logic                        ms_tick,
  input  logic                        chip_en,
  output logic [NUM_WORDS*WORD_W-1:0] cfg_words,
  output logic [2:0]                  state_o,
  output logic                        commit_pulse,
  output logic                        commit_lock,
  output logic                        readback_req,
  output logic                        pwr_dn
);
  localparam int LW = $clog2(CMD_LEN + 1);

  cfg_state_e         state_q, state_d;
  logic               locked_q, locked_d;
  logic               cpulse_d, clock_d, rbreq_d;
  logic               in_commit, frame_done, dwell_done, rb_done;
  logic               fr_clr, wr_en;
  logic [LW-1:0]      frame_len;
  logic [CMD_LEN-1:0] fw;
  logic [ADDR_W-1:0]  tgt;
  logic [WORD_W-1:0]  payload;

  assign in_commit = (state_q == ST_CMT_LOCK) || (state_q == ST_CMT_OPEN);
  assign frame_len = (state_q == ST_IDLE) ? LW'(ENTRY_LEN) : LW'(CMD_LEN);
  assign fr_clr    = tmo || (state_q == ST_RDBK);
  assign tgt       = {fw[CMD_LEN-3], fw[CMD_LEN-2], fw[CMD_LEN-1]};
  assign payload   = fw[WORD_W-1:0];

  cfg_bit_framer #(.MAX_LEN(CMD_LEN)) u_framer (
    .clk, .rst_n, .clr(fr_clr), .bit_stb, .bit_val,
    .frame_len, .frame_done, .frame_word(fw)
  );

  cfg_evt_count #(.LIMIT(DWELL_MS)) u_dwell (
    .clk, .rst_n, .en(in_commit), .inc(ms_tick), .reached(dwell_done)
  );

  cfg_evt_count #(.LIMIT(RB_STROBES)) u_rbcnt (
    .clk, .rst_n, .en(state_q == ST_RDBK), .inc(bit_stb), .reached(rb_done)
  );

  cfg_shadow_bank #(.N(NUM_WORDS), .W(WORD_W)) u_bank (
    .clk, .rst_n, .wr_en, .wr_idx(tgt[IDX_W-1:0]), .wr_data(payload),
    .words_o(cfg_words)
  );

  always_comb begin
    state_d  = state_q;
    locked_d = locked_q;
    cpulse_d = 1'b0;
    clock_d  = commit_lock;
    rbreq_d  = 1'b0;
    wr_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (frame_done) begin
        if (fw[ENTRY_LEN-1:0] == SEQ_PROG) begin
          state_d = ST_PROG;
        end else if (fw[ENTRY_LEN-1:0] == SEQ_RDBK) begin
          state_d = ST_RDBK;
          rbreq_d = 1'b1;
        end
      end
      ST_PROG: if (frame_done) begin
        if (tgt == JMP_TAG) begin
          if (payload == JMP_LOCK || payload == JMP_OPEN) begin
            state_d  = (payload == JMP_LOCK) ? ST_CMT_LOCK : ST_CMT_OPEN;
            cpulse_d = !locked_q;
            if (!locked_q) begin
              clock_d  = (payload == JMP_LOCK);
              locked_d = (payload == JMP_LOCK);
            end
          end else begin
            state_d = ST_IDLE;
          end
        end else if (tgt < ADDR_W'(NUM_WORDS)) begin
          wr_en = 1'b1;
        end
      end
      ST_CMT_LOCK, ST_CMT_OPEN:
        if (frame_done && tgt == JMP_TAG && payload == JMP_EXIT && dwell_done)
          state_d = ST_IDLE;
      ST_RDBK: if (rb_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      locked_q     <= 1'b0;
      commit_pulse <= 1'b0;
      commit_lock  <= 1'b0;
      readback_req <= 1'b0;
    end else begin
      state_q      <= state_d;
      locked_q     <= locked_d;
      commit_pulse <= cpulse_d;
      commit_lock  <= clock_d;
      readback_req <= rbreq_d;
    end
  end

  assign state_o = state_q;
  assign pwr_dn  = (state_q == ST_IDLE) && !chip_en;

  // R7
  commit_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (in_commit && $past(state_q) == ST_PROG));
  // R10
  sealed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !commit_pulse) |=> !commit_pulse);
  // R9
  dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_commit && !dwell_done) |=> (state_q != ST_IDLE));
  // R3
  rdbk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readback_req |-> (state_q == ST_RDBK && $past(state_q) == ST_IDLE));
endmodule

// File: tb/cfg_cmd_fsm_tb.sv
module cfg_cmd_fsm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_val = 1'b0, bit_stb = 1'b0, tmo = 1'b0, ms_tick = 1'b0;
  logic        chip_en = 1'b0;
  logic [47:0] cfg_words;
  logic [2:0]  state_o;
  logic        commit_pulse, commit_lock, readback_req, pwr_dn;

  int n_run = 0, n_fail = 0;
  int cp_seen = 0, rb_seen = 0;
  logic lk_seen = 1'b0;
  bit tick_on = 1'b0, done = 1'b0;

  logic [47:0] exp_w = '0;
  int exp_cp = 0, exp_rb = 0;
  logic exp_lk = 1'b0;

  typedef struct {
    string       rq;
    logic [2:0]  st;
    logic [47:0] w;
    int          cp;
    logic        lk;
    int          rb;
  } item_t;
  item_t sb_q[$];

  cfg_cmd_fsm u_dut (
    .clk, .rst_n, .bit_val, .bit_stb, .tmo, .ms_tick, .chip_en,
    .cfg_words, .state_o, .commit_pulse, .commit_lock, .readback_req, .pwr_dn
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && commit_pulse) begin cp_seen++; lk_seen = commit_lock; end
    if (rst_n && readback_req) rb_seen++;
  end

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      ms_tick = tick_on && (c % 4 == 0);
    end
  end

  task automatic chk(input string rq, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_run++;
        if (state_o !== it.st || cfg_words !== it.w || cp_seen != it.cp ||
            lk_seen !== it.lk || rb_seen != it.rb) begin
          n_fail++;
          $display("FAIL %s actual st=%0d w=%h cp=%0d lk=%b rb=%0d expected st=%0d w=%h cp=%0d lk=%b rb=%0d",
                   it.rq, state_o, cfg_words, cp_seen, lk_seen, rb_seen,
                   it.st, it.w, it.cp, it.lk, it.rb);
        end
      end
    end
  end

  task automatic expect_now(input string rq, input logic [2:0] st);
    item_t it;
    it.rq = rq; it.st = st; it.w = exp_w; it.cp = exp_cp; it.lk = exp_lk; it.rb = exp_rb;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_val = b;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic send_bits(input logic [10:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [2:0] a, input logic [7:0] p);
    send_bits({a, p}, 11);
  endtask

  task automatic enter_prog();
    send_bits(11'b001100, 6);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", {45'd0, state_o}, 48'd0);
    chk("R1 words", cfg_words, 48'd0);
    chk("R1 pulses", {45'd0, commit_pulse, commit_lock, readback_req}, 48'd0);
    // R11 idle passes chip enable
    chk("R11 idle ce=0", {47'd0, pwr_dn}, 48'd1);
    chip_en = 1'b1; @(negedge clk);
    chk("R11 idle ce=1", {47'd0, pwr_dn}, 48'd0);
    chip_en = 1'b0;

    // R4 unknown entry pattern
    send_bits(11'b101010, 6);
    expect_now("R4 bad entry", 3'd0);

    // R5 timeout discards partial entry, then R2 entry
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    @(negedge clk); tmo = 1'b1; @(negedge clk); tmo = 1'b0;
    enter_prog();
    expect_now("R5/R2 enter programming", 3'd1);
    chk("R11 prog ignores ce", {47'd0, pwr_dn}, 48'd0);

    // R6 word writes with address encodings
    send_cmd(3'b000, 8'hA5); exp_w[7:0]   = 8'hA5; expect_now("R6 word0", 3'd1);
    send_cmd(3'b001, 8'h3C); exp_w[39:32] = 8'h3C; expect_now("R6 word4", 3'd1);
    send_cmd(3'b101, 8'h81); exp_w[47:40] = 8'h81; expect_now("R6 word5", 3'd1);
    send_cmd(3'b100, 8'h12); exp_w[15:8]  = 8'h12; expect_now("R6 word1", 3'd1);
    send_cmd(3'b010, 8'h34); exp_w[23:16] = 8'h34; expect_now("R6 word2", 3'd1);
    send_cmd(3'b110, 8'h56); exp_w[31:24] = 8'h56; expect_now("R6 word3", 3'd1);

    // R7 open commit
    send_cmd(3'b111, 8'hF0); exp_cp = 1; exp_lk = 1'b0;
    expect_now("R7 open commit", 3'd3);
    // R12 writes ignored in commit
    send_cmd(3'b000, 8'hFF);
    expect_now("R12 write in commit ignored", 3'd3);
    // R9 early exit ignored
    send_cmd(3'b111, 8'h00);
    expect_now("R9 early exit ignored", 3'd3);
    tick_on = 1'b1;
    repeat (60) @(negedge clk);
    send_cmd(3'b111, 8'h00);
    expect_now("R9 exit after dwell", 3'd0);

    // R7 sealing commit
    enter_prog();
    send_cmd(3'b111, 8'h55); exp_cp = 2; exp_lk = 1'b1;
    expect_now("R7 sealing commit", 3'd2);
    repeat (60) @(negedge clk);
    send_cmd(3'b111, 8'h00);
    expect_now("R9 exit sealing", 3'd0);

    // R10 no further commit pulse
    enter_prog();
    send_cmd(3'b111, 8'hF0);
    expect_now("R10 commit after seal silent", 3'd3);
    repeat (60) @(negedge clk);
    send_cmd(3'b111, 8'h00);
    expect_now("R10 exit", 3'd0);

    // R8 other jumps leave programming
    enter_prog();
    send_cmd(3'b111, 8'h33);
    expect_now("R8 other jump", 3'd0);
    enter_prog();
    send_cmd(3'b111, 8'h00);
    expect_now("R8 exit code from prog", 3'd0);

    // R3 readback
    send_bits(11'b111011, 6); exp_rb = 1;
    expect_now("R3 enter readback", 3'd4);
    chk("R11 readback ignores ce", {47'd0, pwr_dn}, 48'd0);
    for (int i = 0; i < 59; i++) send_bit(1'b1);
    @(negedge clk);
    expect_now("R3 readback before last strobe", 3'd4);
    send_bit(1'b0);
    @(negedge clk);
    expect_now("R3 readback returns idle", 3'd0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule